// File: doc/BRIEF.md
# Programmable Tick Timer

This block is a free-running tick timer controlled through two special-purpose registers. The control register selects one of four operating modes, enables the interrupt, holds a sticky pending flag and stores a 28-bit compare period. The count register holds the 32-bit running count. Software can write either register at any time and can read either one back.

The counter does not run or stop on every control write. It starts only when a write changes the mode field from one value to another non-disabled value, and it stops only when a write changes the mode field to disabled. When the low 28 bits of the running count equal the period, the block sets the pending flag if interrupts are enabled. The count then restarts from zero, freezes at that value, or keeps counting, depending on the mode. The interrupt request to the core is the pending flag gated by the enable bit.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset, the control register reads 0, the count reads 0, `tick_irq` is 0, and the count does not advance.
- R2: A control write that changes the mode field (bits 31:30) to 00 (disabled) stops the counter. The count then holds its value until software writes it.
- R3: A control write that changes the mode field to 01, 10 or 11 starts the counter. The counter then adds one each clock cycle, beginning on the cycle after the write. A control write that leaves the mode field unchanged does not start or stop the counter.
- R4: While the counter runs and count[27:0] equals the period (bits 27:0), the pending flag (bit 28) becomes 1 at the next clock edge if interrupt enable (bit 29) is 1. If interrupt enable is 0, the pending flag is not set.
- R5: In restart mode (01), the count becomes 0 at the edge where a match is taken.
- R6: In single-shot mode (10), the counter stops at a match, and the count holds the period value.
- R7: In continuous mode (11), the count keeps incrementing through and past a match.
- R8: A control write with bit 28 = 1 leaves the pending flag as it was. A control write with bit 28 = 0 clears it.
- R9: `tick_irq` equals the pending flag ANDed with interrupt enable, so clearing the pending flag drops the request.
- R10: A count write (`wr_sel` = 1) loads the written value at the next edge, ahead of any increment. The compare then evaluates against the loaded value.
- R11: If a control write that clears the pending flag lands on the same edge as a match with interrupt enable set, the pending flag is set.
- R12: `rd_data` returns the control register when `rd_sel` = 0, with fields at the bit positions above. It returns the current count when `rd_sel` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 count |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 control, 1 count |
| rd_data | output | 32 | Read data |
| tick_irq | output | 1 | Timer interrupt request |

## Verification
Two functions can fall on the same clock edge: a software write that clears the pending flag, and a hardware match that sets it. The bench provokes this by loading the count with exactly the period and issuing the clearing control write on the very next edge. The match is then active during the same cycle as the clear. The bench expects `tick_irq` to stay high after that edge. A control run clears the flag one cycle away from any match and expects `tick_irq` to fall.

// File: rtl/tt_pkg.sv
package tt_pkg;

    localparam int CNT_W   = 32;
    localparam int PER_W   = 28;
    localparam int MODE_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        TM_OFF     = 2'b00,
        TM_RESTART = 2'b01,
        TM_ONESHOT = 2'b10,
        TM_CONT    = 2'b11
    } tmode_e;

    typedef enum logic {
        SEL_CTRL  = 1'b0,
        SEL_COUNT = 1'b1
    } tsel_e;

    // Field order matches the register word, most significant first.
    typedef struct packed {
        tmode_e            mode;
        logic              ie;
        logic              pend;
        logic [PER_W-1:0]  period;
    } tctrl_t;

    function automatic tctrl_t word_to_ctrl(input logic [CNT_W-1:0] w);
        return tctrl_t'(w);
    endfunction

    function automatic logic [CNT_W-1:0] ctrl_to_word(input tctrl_t c);
        return CNT_W'(c);
    endfunction

endpackage

// File: rtl/tt_ctrl_reg.sv
module tt_ctrl_reg
    import tt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             match_i,
    output tctrl_t           ctrl_o,
    output logic             start_o,
    output logic             stop_o
);

    tctrl_t ctrl_q;
    tctrl_t ctrl_d;
    tctrl_t wr_c;
    logic   mode_chg;
    logic   set_pend;

    always_comb begin
        wr_c     = word_to_ctrl(wdata_i);
        mode_chg = wr_i && (wr_c.mode != ctrl_q.mode);
        start_o  = mode_chg && (wr_c.mode != TM_OFF);
        stop_o   = mode_chg && (wr_c.mode == TM_OFF);
        set_pend = match_i && ctrl_q.ie;
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_i) begin
            ctrl_d.mode   = wr_c.mode;
            ctrl_d.ie     = wr_c.ie;
            ctrl_d.period = wr_c.period;
            // writing 1 keeps the flag, writing 0 clears it
            ctrl_d.pend   = wr_c.pend & ctrl_q.pend;
        end
        if (set_pend) begin
            ctrl_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o = ctrl_q;

    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        (match_i && ctrl_q.ie) |=> ctrl_q.pend);

    a_r8_keep_on_one: assert property (@(posedge clk) disable iff (rst)
        (wr_i && wdata_i[PER_W] && !match_i) |=> $stable(ctrl_q.pend));

    a_r8_clear_on_zero: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !wdata_i[PER_W] && !match_i) |=> !ctrl_q.pend);

    a_r4_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!wr_i && !match_i) |=> $stable(ctrl_q));

endmodule

// File: rtl/tt_counter.sv
module tt_counter
    import tt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  tmode_e           mode_i,
    input  logic [PER_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             running_q;
    logic             running_d;
    logic             match;

    assign match = running_q && (cnt_q[PER_W-1:0] == period_i);

    always_comb begin
        running_d = running_q;
        if (start_i) begin
            running_d = 1'b1;
        end else if (stop_i) begin
            running_d = 1'b0;
        end else if (match && (mode_i == TM_ONESHOT)) begin
            running_d = 1'b0;
        end
    end

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_wr_i) begin
            cnt_d = cnt_wdata_i;
        end else if (match) begin
            unique case (mode_i)
                TM_RESTART: cnt_d = '0;
                TM_ONESHOT: cnt_d = cnt_q;
                default:    cnt_d = cnt_q + CNT_W'(1);
            endcase
        end else if (running_q) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            running_q <= running_d;
        end
    end

    assign cnt_o   = cnt_q;
    assign match_o = match;

    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (rst)
        (!running_q && !cnt_wr_i) |=> $stable(cnt_q));

    a_r3_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (running_q && !cnt_wr_i && !match) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    a_r5_restart_zero: assert property (@(posedge clk) disable iff (rst)
        (match && mode_i == TM_RESTART && !cnt_wr_i) |=> (cnt_q == '0));

    a_r6_oneshot_halts: assert property (@(posedge clk) disable iff (rst)
        (match && mode_i == TM_ONESHOT && !start_i) |=> !running_q);

    a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
        cnt_wr_i |=> (cnt_q == $past(cnt_wdata_i)));

endmodule

// File: rtl/tt_read_mux.sv
module tt_read_mux
    import tt_pkg::*;
(
    input  logic             sel_i,
    input  tctrl_t           ctrl_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] rd_o
);

    always_comb begin
        unique case (tsel_e'(sel_i))
            SEL_COUNT: rd_o = cnt_i;
            default:   rd_o = ctrl_to_word(ctrl_i);
        endcase
    end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             tick_irq
);

    tctrl_t           ctrl;
    logic             ctrl_wr;
    logic             cnt_wr;
    logic             start;
    logic             stop;
    logic             match;
    logic [CNT_W-1:0] cnt;

    assign ctrl_wr = wr_en && (tsel_e'(wr_sel) == SEL_CTRL);
    assign cnt_wr  = wr_en && (tsel_e'(wr_sel) == SEL_COUNT);

    tt_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (ctrl_wr),
        .wdata_i (wr_data),
        .match_i (match),
        .ctrl_o  (ctrl),
        .start_o (start),
        .stop_o  (stop)
    );

    tt_counter u_cnt (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .stop_i      (stop),
        .cnt_wr_i    (cnt_wr),
        .cnt_wdata_i (wr_data),
        .mode_i      (ctrl.mode),
        .period_i    (ctrl.period),
        .cnt_o       (cnt),
        .match_o     (match)
    );

    tt_read_mux u_rd (
        .sel_i  (rd_sel),
        .ctrl_i (ctrl),
        .cnt_i  (cnt),
        .rd_o   (rd_data)
    );

    assign tick_irq = ctrl.pend & ctrl.ie;

    a_r9_irq_drops_on_clear: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !wr_data[PER_W] && !match) |=> !tick_irq);

    a_r4_no_flag_without_enable: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.ie && !ctrl.pend && !ctrl_wr) |=> !tick_irq);

endmodule

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        tick_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tick_timer dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .tick_irq (tick_irq)
    );

    function automatic logic [31:0] mk(input logic [1:0] m, input logic ie,
                                       input logic pd, input int per);
        return {m, ie, pd, 28'(per)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic chk_cnt(input string req, input logic [31:0] exp);
        logic [31:0] v;
        rd(1'b1, v);
        chk(req, v, exp);
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(1'b0, v);
        chk("R1 ctrl", v, 32'h0);
        chk_cnt("R1 count", 32'h0);
        chk("R1 irq", {31'h0, tick_irq}, 32'h0);
        waitc(3);
        chk_cnt("R1 idle count", 32'h0);

        // R7 continuous sweep over small periods
        for (int p = 2; p <= 6; p++) begin
            wr(1'b0, mk(2'b00, 1'b0, 1'b0, 0));
            wr(1'b1, 32'h0);
            wr(1'b0, mk(2'b11, 1'b1, 1'b0, p));
            chk_cnt("R3 start", 32'h0);
            waitc(p);
            chk_cnt("R3 count reaches period", 32'(p));
            chk("R4 no early flag", {31'h0, tick_irq}, 32'h0);
            waitc(1);
            chk("R4 flag after match", {31'h0, tick_irq}, 32'h1);
            chk_cnt("R7 passes match", 32'(p + 1));
            waitc(4);
            chk_cnt("R7 keeps counting", 32'(p + 5));
            wr(1'b0, mk(2'b11, 1'b1, 1'b1, p));
            chk("R8 write one keeps", {31'h0, tick_irq}, 32'h1);
            wr(1'b0, mk(2'b11, 1'b1, 1'b0, p));
            chk("R9 clear drops irq", {31'h0, tick_irq}, 32'h0);
        end

        // R5 restart sweep, R2 stop
        for (int p = 2; p <= 7; p += 2) begin
            wr(1'b0, mk(2'b00, 1'b0, 1'b0, 0));
            rd(1'b1, held);
            waitc(3);
            chk_cnt("R2 stopped holds", held);
            wr(1'b1, 32'h0);
            chk_cnt("R10 load while stopped", 32'h0);
            wr(1'b0, mk(2'b01, 1'b1, 1'b0, p));
            waitc(p);
            chk_cnt("R5 at period", 32'(p));
            waitc(1);
            chk_cnt("R5 zeroed", 32'h0);
            chk("R5 flag", {31'h0, tick_irq}, 32'h1);
            waitc(2);
            chk_cnt("R5 counts again", 32'h2);
        end

        // R6 single-shot sweep
        for (int p = 3; p <= 7; p += 2) begin
            wr(1'b0, mk(2'b00, 1'b0, 1'b0, 0));
            wr(1'b1, 32'h0);
            wr(1'b0, mk(2'b10, 1'b1, 1'b0, p));
            waitc(p + 1);
            chk_cnt("R6 frozen at period", 32'(p));
            chk("R6 flag", {31'h0, tick_irq}, 32'h1);
            waitc(5);
            chk_cnt("R6 stays frozen", 32'(p));
            wr(1'b0, mk(2'b10, 1'b1, 1'b0, p));
            chk("R8 clear", {31'h0, tick_irq}, 32'h0);
            waitc(3);
            chk_cnt("R3 same mode no restart", 32'(p));
            chk("R6 no refire", {31'h0, tick_irq}, 32'h0);
        end

        // R4 enable off, R12 readback
        wr(1'b0, mk(2'b00, 1'b0, 1'b0, 0));
        wr(1'b1, 32'h0);
        wr(1'b0, mk(2'b11, 1'b0, 1'b0, 3));
        waitc(6);
        chk("R4 no flag when disabled", {31'h0, tick_irq}, 32'h0);
        rd(1'b0, v);
        chk("R12 ctrl readback", v, mk(2'b11, 1'b0, 1'b0, 3));
        chk_cnt("R12 live count", 32'h6);

        // R10 count write re-evaluates compare
        wr(1'b0, mk(2'b11, 1'b1, 1'b0, 9));
        wr(1'b1, 32'h7);
        chk_cnt("R10 loaded", 32'h7);
        waitc(1);
        chk_cnt("R10 increments", 32'h8);
        waitc(1);
        chk("R10 no flag yet", {31'h0, tick_irq}, 32'h0);
        waitc(1);
        chk("R10 flag after loaded match", {31'h0, tick_irq}, 32'h1);
        rd(1'b0, v);
        chk("R12 pend bit visible", {31'h0, v[28]}, 32'h1);

        // R11 clear on the same edge as a match
        wr(1'b1, 32'h9);
        wr(1'b0, mk(2'b11, 1'b1, 1'b0, 9));
        chk("R11 set beats clear", {31'h0, tick_irq}, 32'h1);
        wr(1'b1, 32'd20);
        wr(1'b0, mk(2'b11, 1'b1, 1'b0, 9));
        chk("R11 plain clear", {31'h0, tick_irq}, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule